// File: doc/BRIEF.md
# Arithmetic Flag ALU

A purely combinational datapath slice for a small accumulator processor. It takes the accumulator value, a second operand, the current carry flag and a two-bit operation code. It returns the 8-bit result together with the new values of the carry, overflow and parity flags. A per-bit write-enable mask is placed in the positions those flags hold in the processor status word.

The supported operations are subtract-with-borrow, bitwise exclusive-or and a rotate right that does not pass through the carry. A fourth code passes the accumulator through unchanged. The sequencer that owns the status word merges the flag value vector into the status word under the write mask. The flag rules follow the processor's own conventions:

- Carry is a borrow taken from an unsigned compare.
- Overflow is the signed subtract overflow.
- Parity is even parity over the result, so it is set when the result has an odd number of ones.

Top module: `arith_flag_alu`

## Requirements
- R1: `op_i` encodes the operation as 0 = subtract with borrow, 1 = exclusive-or, 2 = rotate right, 3 = pass accumulator.
- R2: For subtract, `res_o` equals (`acc_i` − `opnd_i` − `cy_i`) modulo 256.
- R3: For subtract, the carry value is 1 exactly when `acc_i` < `opnd_i` + `cy_i`, compared as unsigned integers wide enough not to wrap.
- R4: For subtract, the overflow value is 1 exactly when the signed difference `acc_i` − `opnd_i` − `cy_i` lies outside −128..127. This is the case where the minuend and operand differ in sign and the result's sign differs from the minuend's.
- R5: Whenever parity is written (subtract and exclusive-or), its value is the XOR of all eight bits of `res_o`.
- R6: For exclusive-or, `res_o` = `acc_i` ^ `opnd_i`. Carry is written as 0, parity is written, and overflow is not written.
- R7: For rotate right, `res_o` takes `acc_i` bit 0 into bit 7 and shifts bits 7..1 down by one. No flag write enable is set.
- R8: Flag positions in `flag_val_o` and `flag_we_o` are: carry in bit 7, overflow in bit 2, parity in bit 0. All other bits of both vectors are 0, and a value bit is 0 whenever its enable bit is 0.
- R9: For pass, `res_o` = `acc_i` and no flag write enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand (minuend) |
| opnd_i | input | 8 | Second operand |
| cy_i | input | 1 | Incoming carry flag |
| op_i | input | 2 | Operation select |
| res_o | output | 8 | Operation result |
| flag_val_o | output | 8 | New flag values at status-word positions |
| flag_we_o | output | 8 | Per-bit flag write enables |

## Verification
The subtract path is driven exhaustively: every accumulator and operand pair, with both carry-in values. This separates the borrow compare from plain 8-bit wrap and catches the off-by-carry cases at the boundaries 0x00, 0x7F, 0x80 and 0xFF. The same sweep tells a minuend-sign overflow rule apart from an operand-sign rule. Exclusive-or, rotate and pass are tried with seeded random operands and with both carry values, to show that the carry input never leaks into their results or flags. Directed all-zero, all-one and single-bit patterns confirm the rotate wrap of bit 0 and the parity polarity.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [1:0] {
    OP_SUBB = 2'd0,
    OP_XOR  = 2'd1,
    OP_ROR  = 2'd2,
    OP_PASS = 2'd3
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int CY_POS = 7;
  localparam int OV_POS = 2;
  localparam int P_POS  = 0;
endpackage

// File: rtl/afa_subb.sv
module afa_subb #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         borrow_o,
  output logic         ov_o
);
  logic [W:0] diff;

  // extra bit catches the borrow: a < b + cy
  assign diff     = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cy_i};
  assign res_o    = diff[W-1:0];
  assign borrow_o = diff[W];
  assign ov_o     = (a_i[W-1] ^ b_i[W-1]) & (a_i[W-1] ^ diff[W-1]);
endmodule

// File: rtl/afa_parity.sv
module afa_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         par_o
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ d_i[i];
  end
  assign par_o = chain[W];
endmodule

// File: rtl/afa_ror.sv
module afa_ror #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_rot
    assign q_o[i] = d_i[(i + 1) % W];
  end
endmodule

// File: rtl/arith_flag_alu.sv
module arith_flag_alu
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      acc_i,
  input  logic [W-1:0]      opnd_i,
  input  logic              cy_i,
  input  logic [1:0]        op_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] flag_val_o,
  output logic [FLAG_W-1:0] flag_we_o
);
  alu_op_e     op;
  logic [W-1:0] sub_res, ror_res;
  logic         sub_borrow, sub_ov, par;

  assign op = alu_op_e'(op_i);

  afa_subb #(.W(W)) u_subb (
    .a_i      (acc_i),
    .b_i      (opnd_i),
    .cy_i     (cy_i),
    .res_o    (sub_res),
    .borrow_o (sub_borrow),
    .ov_o     (sub_ov)
  );

  afa_ror #(.W(W)) u_ror (
    .d_i (acc_i),
    .q_o (ror_res)
  );

  afa_parity #(.W(W)) u_par (
    .d_i   (res_o),
    .par_o (par)
  );

  always_comb begin
    flag_val_o = '0;
    flag_we_o  = '0;
    unique case (op)
      OP_SUBB: begin
        res_o              = sub_res;
        flag_we_o[CY_POS]  = 1'b1;
        flag_we_o[OV_POS]  = 1'b1;
        flag_we_o[P_POS]   = 1'b1;
        flag_val_o[CY_POS] = sub_borrow;
        flag_val_o[OV_POS] = sub_ov;
        flag_val_o[P_POS]  = par;
      end
      OP_XOR: begin
        res_o             = acc_i ^ opnd_i;
        flag_we_o[CY_POS] = 1'b1;
        flag_we_o[P_POS]  = 1'b1;
        flag_val_o[P_POS] = par;
      end
      OP_ROR:  res_o = ror_res;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/arith_flag_alu_chk.sv
module arith_flag_alu_chk
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0]      acc_i,
  input logic [W-1:0]      opnd_i,
  input logic              cy_i,
  input logic [1:0]        op_i,
  input logic [W-1:0]      res_o,
  input logic [FLAG_W-1:0] flag_val_o,
  input logic [FLAG_W-1:0] flag_we_o
);
  logic known;
  assign known = !$isunknown({acc_i, opnd_i, cy_i, op_i});

  always_comb begin
    if (known) begin
      // R3
      borrow_cmp_chk: assert (op_i != OP_SUBB ||
        flag_val_o[CY_POS] == ({1'b0, acc_i} < ({1'b0, opnd_i} + {{W{1'b0}}, cy_i})));
      // R5
      parity_chk: assert (!flag_we_o[P_POS] || flag_val_o[P_POS] == ^res_o);
      // R6
      xor_cy_clear_chk: assert (op_i != OP_XOR ||
        (flag_we_o[CY_POS] && !flag_val_o[CY_POS] && !flag_we_o[OV_POS]));
      // R7
      ror_wrap_chk: assert (op_i != OP_ROR ||
        (res_o[W-1] == acc_i[0] && flag_we_o == '0));
      // R8
      val_under_we_chk: assert ((flag_val_o & ~flag_we_o) == '0);
    end
  end
endmodule

bind arith_flag_alu arith_flag_alu_chk #(.W(W)) u_chk (.*);

// File: tb/arith_flag_alu_bench.sv
module arith_flag_alu_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] acc, opnd;
  logic       cy;
  logic [1:0] op;
  logic [7:0] res, fval, fwe;
  int         n_chk = 0, n_fail = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  arith_flag_alu u_arith_flag_alu (
    .acc_i(acc), .opnd_i(opnd), .cy_i(cy), .op_i(op),
    .res_o(res), .flag_val_o(fval), .flag_we_o(fwe)
  );

  function automatic bit par8(input int v);
    bit p = 0;
    for (int i = 0; i < 8; i++) p ^= v[i];
    return p;
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s a=%02h b=%02h c=%0d op=%0d act=%0h exp=%0h",
               tag, acc, opnd, cy, op, act, exp);
    end
  endtask

  task automatic run(input int a, input int b, input int c, input int o);
    int r, we, cyv, ovv, full;
    @(negedge clk);
    acc = a[7:0]; opnd = b[7:0]; cy = c[0]; op = o[1:0];
    #2;
    cyv = 0; ovv = 0;
    case (o)
      0: begin
        full = a - b - c;
        r    = full & 255;
        we   = 8'h85;
        cyv  = (a < b + c);
        full = (a > 127 ? a - 256 : a) - (b > 127 ? b - 256 : b) - c;
        ovv  = (full < -128 || full > 127);
        cmp("R2 subtract result", res, r);
        cmp("R3 borrow", fval[7], cyv);
        cmp("R4 overflow", fval[2], ovv);
      end
      1: begin
        r  = a ^ b;
        we = 8'h81;
        cmp("R6 xor result", res, r);
        cmp("R6 xor carry cleared", fval[7], 0);
      end
      2: begin
        r  = (a >> 1) | ((a & 1) << 7);
        we = 0;
        cmp("R7 rotate result", res, r);
      end
      default: begin
        r  = a;
        we = 0;
        cmp("R9 pass result", res, r);
      end
    endcase
    cmp("R1 R8 write mask", fwe, we);
    if (we[0]) cmp("R5 parity", fval[0], par8(r));
    cmp("R8 value bits", fval & ~we[7:0], 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    acc = '0; opnd = '0; cy = 1'b0; op = 2'd0;
    void'($urandom(32'd4051));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 R8 all-zero start vector
    run(0, 0, 0, 0);
    // directed corners for R4 R5 R7
    run(8'h80, 8'h01, 0, 0);
    run(8'h7F, 8'hFF, 1, 0);
    run(8'h00, 8'hFF, 1, 0);
    run(8'hFF, 8'hFF, 1, 1);
    run(8'h01, 8'h00, 1, 2);
    run(8'hFE, 8'h00, 1, 2);
    run(8'h5A, 8'h00, 1, 3);
    // exhaustive subtract sweep, R2 R3 R4 R5
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run(a, b, c, 0);
    // random xor, rotate, pass: R6 R7 R9
    for (int k = 0; k < 1500; k++) begin
      run($urandom & 255, $urandom & 255, $urandom & 1, 1);
      run($urandom & 255, $urandom & 255, $urandom & 1, 2);
      run($urandom & 255, $urandom & 255, $urandom & 1, 3);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule